// File: doc/BRIEF.md
# Fault Isolation Register Bank with Action Decode

This block gathers hardware error indications into a bank of sticky fault bits and reports them through three level summaries. Each error input line sets its own bit in a fault register; the bit stays set until software clears it. A mask register hides selected bits from reporting. Two action registers classify every unmasked bit. The action pair 00 routes a bit to the checkstop summary, 01 routes it to the recoverable summary, and any pair with the first action bit set routes it to a third summary.

Software reaches the bank over a small register bus. The bus has a write strobe, a 3-bit word offset from the bank's base, write data and combinational read data. Besides plain read/write locations, the fault and mask registers each have an AND-write alias and an OR-write alias. Software can therefore clear or set individual bits without a read-modify-write, which avoids racing hardware that sets bits at the same time. The register width is a parameter. One instance might use 36 bits and another 10.

Top module: `fault_isolation_reg`

## Requirements
- R1: An error input bit asserted before a clock edge sets the matching fault bit at that edge. The bit then stays set while no write targets offset 0 or offset 1.
- R2: An unmasked fault bit whose action0 and action1 bits are both 0 drives `checkstop` high.
- R3: An unmasked fault bit with action0 = 0 and action1 = 1 drives `recoverable` high and leaves `checkstop` low.
- R4: An unmasked fault bit with action0 = 1 drives `other_act` high, whatever its action1 bit is.
- R5: A masked fault bit (mask bit = 1) contributes to none of the three summaries, and masking does not alter the fault bit itself.
- R6: A write to offset 1 ANDs the write data into the fault register. Bits written as 0 are cleared.
- R7: Offset 0 reads and writes the fault register directly. A write to offset 2 ORs the write data into the fault register.
- R8: Offset 3 reads and writes the mask register directly. A write to offset 4 ANDs the write data into the mask, and a write to offset 5 ORs it into the mask.
- R9: The action0 register reads and writes at offset 6, and the action1 register at offset 7.
- R10: When an error input and a software clear of the same fault bit happen in the same cycle, the bit ends up set.
- R11: After reset the fault register is all zeros, the mask is all ones, both action registers are zero, and all three summaries are low.
- R12: Reads at offsets 1 and 2 return the fault register. Reads at offsets 4 and 5 return the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_in | input | W | Hardware error lines, one per fault bit |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word offset from the bank base |
| wdata | input | W | Write data |
| rdata | output | W | Read data for the register selected by `addr` |
| checkstop | output | 1 | Summary of unmasked faults with action pair 00 |
| recoverable | output | 1 | Summary of unmasked faults with action pair 01 |
| other_act | output | 1 | Summary of unmasked faults with action0 = 1 |

## Verification
The assertions watch several rules on every cycle:
- fault bits never drop without a write to offset 0 or 1;
- every asserted error line is present in the fault register one edge later, which also covers a colliding clear;
- the AND-clear of the fault register and the OR-set of the mask give exactly the expected value;
- an all-ones mask keeps every summary low.

Only the directed scenarios show the rest. These are the routing of a bit through each action encoding, the reset values, the read-back of every offset including the aliases, and the restoration of a summary when a bit is unmasked again.

// File: rtl/fault_isolation_reg.sv
module fault_isolation_reg #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] err_in,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         checkstop,
  output logic         recoverable,
  output logic         other_act
);

  localparam logic [2:0] OFS_FLT     = 3'd0;
  localparam logic [2:0] OFS_FLT_AND = 3'd1;
  localparam logic [2:0] OFS_FLT_OR  = 3'd2;
  localparam logic [2:0] OFS_MSK     = 3'd3;
  localparam logic [2:0] OFS_MSK_AND = 3'd4;
  localparam logic [2:0] OFS_MSK_OR  = 3'd5;
  localparam logic [2:0] OFS_ACT0    = 3'd6;
  localparam logic [2:0] OFS_ACT1    = 3'd7;

  logic [W-1:0] fault_q, mask_q, act0_q, act1_q;
  logic [W-1:0] fault_d, mask_d;
  logic [W-1:0] live;

  always_comb begin
    fault_d = fault_q;
    mask_d  = mask_q;
    if (wr_en) begin
      case (addr)
        OFS_FLT:     fault_d = wdata;
        OFS_FLT_AND: fault_d = fault_q & wdata;
        OFS_FLT_OR:  fault_d = fault_q | wdata;
        OFS_MSK:     mask_d  = wdata;
        OFS_MSK_AND: mask_d  = mask_q & wdata;
        OFS_MSK_OR:  mask_d  = mask_q | wdata;
        default: ;
      endcase
    end
    fault_d = fault_d | err_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= '0;
      mask_q  <= '1;
      act0_q  <= '0;
      act1_q  <= '0;
    end else begin
      fault_q <= fault_d;
      mask_q  <= mask_d;
      if (wr_en && addr == OFS_ACT0) act0_q <= wdata;
      if (wr_en && addr == OFS_ACT1) act1_q <= wdata;
    end
  end

  always_comb begin
    case (addr)
      OFS_FLT, OFS_FLT_AND, OFS_FLT_OR: rdata = fault_q;
      OFS_MSK, OFS_MSK_AND, OFS_MSK_OR: rdata = mask_q;
      OFS_ACT0:                         rdata = act0_q;
      default:                          rdata = act1_q;
    endcase
  end

  assign live        = fault_q & ~mask_q;
  assign checkstop   = |(live & ~act0_q & ~act1_q);
  assign recoverable = |(live & ~act0_q &  act1_q);
  assign other_act   = |(live &  act0_q);

endmodule

// File: rtl/fault_isolation_reg_chk.sv
module fault_isolation_reg_chk #(
  parameter int W = 36
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] err_in,
  input logic         wr_en,
  input logic [2:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] fault_q,
  input logic [W-1:0] mask_q,
  input logic         checkstop,
  input logic         recoverable,
  input logic         other_act
);

  assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == 3'd0 || addr == 3'd1)) |=> (($past(fault_q) & ~fault_q) == '0));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_in != '0) |=> ((fault_q & $past(err_in)) == $past(err_in)));

  assert_and_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && err_in == '0) |=> (fault_q == ($past(fault_q) & $past(wdata))));

  assert_mask_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd5) |=> (mask_q == ($past(mask_q) | $past(wdata))));

  assert_masked_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> (!checkstop && !recoverable && !other_act));

endmodule

bind fault_isolation_reg fault_isolation_reg_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_in(err_in), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .fault_q(fault_q), .mask_q(mask_q), .checkstop(checkstop),
  .recoverable(recoverable), .other_act(other_act)
);

// File: tb/tb_fault_isolation_reg.sv
`timescale 1ns/1ps
module tb_fault_isolation_reg;
  localparam int W = 36;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [W-1:0] err_in = '0, wdata = '0;
  logic [2:0] addr = 3'd0;
  logic [W-1:0] rdata;
  logic checkstop, recoverable, other_act;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  fault_isolation_reg #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .err_in(err_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .checkstop(checkstop),
    .recoverable(recoverable), .other_act(other_act)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic pulse_err(input logic [W-1:0] e);
    @(negedge clk); err_in = e;
    @(negedge clk); err_in = '0;
  endtask

  function automatic logic [W-1:0] sums();
    return {{(W-3){1'b0}}, other_act, recoverable, checkstop};
  endfunction

  task automatic t_reset();
    logic [W-1:0] v;
    rd(3'd0, v); chk("R11 fault", v, '0);
    rd(3'd3, v); chk("R11 mask", v, ONES);
    rd(3'd6, v); chk("R11 act0", v, '0);
    rd(3'd7, v); chk("R11 act1", v, '0);
    chk("R11 summaries", sums(), '0);
  endtask

  task automatic t_sticky_checkstop();
    logic [W-1:0] v;
    wr(3'd3, '0);
    pulse_err(W'(1) << 5);
    repeat (4) @(negedge clk);
    rd(3'd0, v); chk("R1 sticky bit5", v, W'(1) << 5);
    chk("R2 checkstop only", sums(), W'(3'b001));
    wr(3'd1, ~(W'(1) << 5));
    rd(3'd0, v); chk("R6 and-clear", v, '0);
    chk("R6 summaries clear", sums(), '0);
  endtask

  task automatic t_recoverable();
    logic [W-1:0] v;
    wr(3'd7, W'(1) << 3);
    wr(3'd2, W'(1) << 3);
    rd(3'd0, v); chk("R7 or-set fault", v, W'(1) << 3);
    rd(3'd2, v); chk("R12 alias read offset2", v, W'(1) << 3);
    rd(3'd1, v); chk("R12 alias read offset1", v, W'(1) << 3);
    chk("R3 recoverable only", sums(), W'(3'b010));
    rd(3'd7, v); chk("R9 act1 readback", v, W'(1) << 3);
    wr(3'd0, '0);
    rd(3'd0, v); chk("R7 direct write clears", v, '0);
  endtask

  task automatic t_other_and_mask();
    logic [W-1:0] v;
    wr(3'd6, W'(1) << 35);
    wr(3'd7, W'(1) << 35);
    rd(3'd6, v); chk("R9 act0 readback", v, W'(1) << 35);
    pulse_err(W'(1) << 35);
    chk("R4 other on 11", sums(), W'(3'b100));
    wr(3'd5, W'(1) << 35);
    chk("R5 masked silent", sums(), '0);
    rd(3'd0, v); chk("R5 fault kept", v, W'(1) << 35);
    rd(3'd3, v); chk("R8 mask or-set", v, W'(1) << 35);
    rd(3'd5, v); chk("R12 alias read offset5", v, W'(1) << 35);
    wr(3'd4, ~(W'(1) << 35));
    rd(3'd4, v); chk("R8 mask and-clear", v, '0);
    chk("R4 other restored", sums(), W'(3'b100));
    wr(3'd7, '0);
    chk("R4 other on 10", sums(), W'(3'b100));
    wr(3'd3, W'(36'h0_F0F0_F0F0));
    rd(3'd3, v); chk("R8 mask direct", v, W'(36'h0_F0F0_F0F0));
    wr(3'd3, '0);
    wr(3'd0, '0); wr(3'd6, '0);
  endtask

  task automatic t_set_wins();
    logic [W-1:0] v;
    wr(3'd0, W'(36'hF_0000_0081));
    @(negedge clk); wr_en = 1; addr = 3'd1; wdata = '0; err_in = W'(1) << 7;
    @(negedge clk); wr_en = 0; err_in = '0;
    rd(3'd0, v); chk("R10 set beats clear", v, W'(1) << 7);
    chk("R2 checkstop from bit7", sums(), W'(3'b001));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sticky_checkstop();
    t_recoverable();
    t_other_and_mask();
    t_set_wins();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule